// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Cache with Change Tracking

This block caches virtual-to-physical page translations in a small two-way set-associative array. A request carries a virtual address and an access kind (silent probe, data read, data write or instruction fetch). One cycle later the block returns whether the page is present, and if it is, the physical address: the cached physical page joined to the request's 12-bit page offset.

Every way also keeps a copy of the second word of the page-table entry it was filled from. The change bit in that copy gates writes. A write that finds its page but sees the change bit still clear sets the bit in the cached copy and reports a miss. The page-table walker then runs and records the change in memory. A refill port installs walker results. Each installed way becomes the most recent of its set, and the replacement choice uses those most-recent flags. Refills and lookups that come from silent probes leave the cache untouched.

Top module: `tlb2w_cache`

## Requirements
- R1: After reset every way is invalid. The result outputs are all zero, and every lookup misses until a refill installs a page.
- R2: A lookup presented with `lk_valid` high in one cycle gives `res_valid` high in the next cycle. On a hit, `res_paddr` is the cached physical page (bits 31..12) joined to the request's `lk_vaddr[11:0]`.
- R3: A lookup hits only a valid way whose stored tag equals the whole virtual page number `lk_vaddr[31:12]`. A different page that maps to the same set misses.
- R4: The set is selected by `lk_vaddr` (or `fill_vaddr`) bits just above the page offset, `[12 +: log2(SETS)]`. Pages held in different sets do not disturb one another.
- R5: A refill stores the tag `fill_vaddr[31:12]`, the physical page `fill_word[31:12]` and the whole `fill_word` in the chosen way. That way becomes most recent and the other way of the set loses its most-recent flag.
- R6: A refill whose `fill_kind` is probe (encoding 0) is ignored and installs nothing.
- R7: The refill picks its way in this order: a valid way already holding the same tag, then an invalid way (way 0 first), then the way not flagged most recent.
- R8: A read (1) or fetch (3) lookup that hits makes the hit way most recent, so the next refill of that set evicts the other way.
- R9: A write (2) lookup that finds its page with cached change bit `word[7]` at 0 reports a miss. It sets that bit in the cached word and leaves the most-recent flags unchanged. A repeated write to the same page then hits.
- R10: A write lookup to a page whose cached change bit is already 1 hits like a read.
- R11: A probe (0) lookup reports hit or miss and the address normally. It changes no most-recent flag and no change bit.
- R12: When an active refill and a lookup address the same set in the same cycle, the refill wins. The lookup returns the contents from before the refill, and its own flag updates are dropped.
- R13: On a miss, `res_hit` is 0 and `res_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_kind | input | 2 | Access kind: 0 probe, 1 read, 2 write, 3 fetch |
| fill_valid | input | 1 | Refill request strobe |
| fill_vaddr | input | 32 | Virtual address of the page being installed |
| fill_kind | input | 2 | Access kind that caused the refill, same encoding |
| fill_word | input | 32 | Second page-table word; page in [31:12], change bit at [7] |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_paddr | output | 32 | Translated physical address, zero on a miss |

## Verification
Several properties are checked on every cycle. The result follows its request by exactly one cycle and keeps the request's page offset. A miss never carries an address. A set never holds the same page in both ways, and never has both ways flagged most recent. A clean write hit is always reported as a miss. The eviction order needs the bench's scenarios, because the effect of probe and read accesses on the most-recent flags only becomes visible at a later refill. The same goes for the way a repeated write turns from miss to hit, and for how a lookup and a refill to the same set resolve in one cycle.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;
  typedef enum logic [1:0] {
    ACC_PROBE = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_FETCH = 2'd3
  } acc_kind_e;

  localparam int unsigned PAGE_BITS = 12;
endpackage

// File: rtl/tlb2w_way.sv
module tlb2w_way #(
  parameter int unsigned SETS    = 16,
  parameter int unsigned SET_W   = 4,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned CHG_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [SET_W-1:0] fl_set,
  input  logic             fill_we,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [PTE_W-1:0] fill_word,
  input  logic             fl_mru_clr,
  input  logic             lk_mru_we,
  input  logic             lk_mru_val,
  input  logic             lk_chg_we,
  output logic             lk_v,
  output logic             lk_mru,
  output logic [TAG_W-1:0] lk_tag,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [PTE_W-1:0] lk_word,
  output logic             fl_v,
  output logic             fl_mru,
  output logic [TAG_W-1:0] fl_tag
);
  logic [SETS-1:0]  v_q,   v_n;
  logic [SETS-1:0]  mru_q, mru_n;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [TAG_W-1:0] tag_n  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  logic [PPN_W-1:0] ppn_n  [SETS];
  logic [PTE_W-1:0] word_q [SETS];
  logic [PTE_W-1:0] word_n [SETS];
  logic             st_en;

  assign lk_v    = v_q[lk_set];
  assign lk_mru  = mru_q[lk_set];
  assign lk_tag  = tag_q[lk_set];
  assign lk_ppn  = ppn_q[lk_set];
  assign lk_word = word_q[lk_set];
  assign fl_v    = v_q[fl_set];
  assign fl_mru  = mru_q[fl_set];
  assign fl_tag  = tag_q[fl_set];

  assign st_en = fill_we | fl_mru_clr | lk_mru_we | lk_chg_we;

  always_comb begin
    v_n    = v_q;
    mru_n  = mru_q;
    tag_n  = tag_q;
    ppn_n  = ppn_q;
    word_n = word_q;
    if (lk_mru_we) mru_n[lk_set] = lk_mru_val;
    if (lk_chg_we) word_n[lk_set][CHG_BIT] = 1'b1;
    if (fill_we) begin
      v_n[fl_set]    = 1'b1;
      mru_n[fl_set]  = 1'b1;
      tag_n[fl_set]  = fill_tag;
      ppn_n[fl_set]  = fill_ppn;
      word_n[fl_set] = fill_word;
    end
    if (fl_mru_clr) mru_n[fl_set] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      mru_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        ppn_q[s]  <= '0;
        word_q[s] <= '0;
      end
    end else if (st_en) begin
      v_q    <= v_n;
      mru_q  <= mru_n;
      tag_q  <= tag_n;
      ppn_q  <= ppn_n;
      word_q <= word_n;
    end
  end
endmodule

// File: rtl/tlb2w_victim.sv
module tlb2w_victim (
  input  logic [1:0] way_v,
  input  logic [1:0] way_mru,
  input  logic [1:0] way_match,
  output logic       victim
);
  always_comb begin
    if (way_match[0])      victim = 1'b0;
    else if (way_match[1]) victim = 1'b1;
    else if (!way_v[0])    victim = 1'b0;
    else if (!way_v[1])    victim = 1'b1;
    else if (way_mru[0])   victim = 1'b1;
    else                   victim = 1'b0;
  end
endmodule

// File: rtl/tlb2w_cache.sv
module tlb2w_cache
  import tlb2w_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned SETS    = 16,
  parameter int unsigned CHG_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic [1:0]      lk_kind,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic [1:0]      fill_kind,
  input  logic [PTE_W-1:0] fill_word,
  output logic            res_valid,
  output logic            res_hit,
  output logic [PA_W-1:0] res_paddr
);
  localparam int unsigned PG    = PAGE_BITS;
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = VA_W - PG;
  localparam int unsigned PPN_W = PA_W - PG;

  acc_kind_e lk_k, fl_k;
  assign lk_k = acc_kind_e'(lk_kind);
  assign fl_k = acc_kind_e'(fill_kind);

  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag_in, fl_tag_in;
  assign lk_set    = lk_vaddr[PG +: SET_W];
  assign fl_set    = fill_vaddr[PG +: SET_W];
  assign lk_tag_in = lk_vaddr[VA_W-1:PG];
  assign fl_tag_in = fill_vaddr[VA_W-1:PG];

  logic [1:0]       lk_v, lk_mru_vec, lk_match, fl_v, fl_mru, fl_match;
  logic [1:0]       fill_we, fl_mru_clr, lk_mru_we, lk_mru_val, lk_chg_we;
  logic [TAG_W-1:0] lk_tag [2];
  logic [TAG_W-1:0] fl_tag [2];
  logic [PPN_W-1:0] lk_ppn [2];
  logic [PTE_W-1:0] lk_word [2];

  logic hit_any, hit_w, is_wr, is_probe, wr_clean_hit, rep_hit;
  logic fill_act, collide, upd_ok, victim;

  assign hit_any      = |lk_match;
  assign hit_w        = !lk_match[0];
  assign is_wr        = (lk_k == ACC_WRITE);
  assign is_probe     = (lk_k == ACC_PROBE);
  assign wr_clean_hit = hit_any && is_wr && !lk_word[hit_w][CHG_BIT];
  assign rep_hit      = hit_any && !wr_clean_hit;
  assign fill_act     = fill_valid && (fl_k != ACC_PROBE);
  assign collide      = fill_act && (fl_set == lk_set);
  assign upd_ok       = lk_valid && !is_probe && !collide;

  tlb2w_victim u_victim (
    .way_v     (fl_v),
    .way_mru   (fl_mru),
    .way_match (fl_match),
    .victim    (victim)
  );

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign lk_match[w]   = lk_v[w] && (lk_tag[w] == lk_tag_in);
    assign fl_match[w]   = fl_v[w] && (fl_tag[w] == fl_tag_in);
    assign fill_we[w]    = fill_act && (victim == w[0]);
    assign fl_mru_clr[w] = fill_act && (victim != w[0]);
    assign lk_mru_we[w]  = upd_ok && rep_hit;
    assign lk_mru_val[w] = (hit_w == w[0]);
    assign lk_chg_we[w]  = upd_ok && wr_clean_hit && (hit_w == w[0]);

    tlb2w_way #(
      .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W),
      .PPN_W(PPN_W), .PTE_W(PTE_W), .CHG_BIT(CHG_BIT)
    ) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_set     (lk_set),
      .fl_set     (fl_set),
      .fill_we    (fill_we[w]),
      .fill_tag   (fl_tag_in),
      .fill_ppn   (fill_word[PA_W-1:PG]),
      .fill_word  (fill_word),
      .fl_mru_clr (fl_mru_clr[w]),
      .lk_mru_we  (lk_mru_we[w]),
      .lk_mru_val (lk_mru_val[w]),
      .lk_chg_we  (lk_chg_we[w]),
      .lk_v       (lk_v[w]),
      .lk_mru     (lk_mru_vec[w]),
      .lk_tag     (lk_tag[w]),
      .lk_ppn     (lk_ppn[w]),
      .lk_word    (lk_word[w]),
      .fl_v       (fl_v[w]),
      .fl_mru     (fl_mru[w]),
      .fl_tag     (fl_tag[w])
    );
  end

  logic unused_bits;
  assign unused_bits = ^{fill_vaddr[PG-1:0], lk_word[0], lk_word[1], lk_mru_vec};

  logic            res_valid_n, res_hit_n;
  logic [PA_W-1:0] res_paddr_n;

  always_comb begin
    res_valid_n = lk_valid;
    res_hit_n   = lk_valid && rep_hit;
    res_paddr_n = '0;
    if (lk_valid && rep_hit) res_paddr_n = {lk_ppn[hit_w], lk_vaddr[PG-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= res_valid_n;
      res_hit   <= res_hit_n;
      res_paddr <= res_paddr_n;
    end
  end
endmodule

// File: rtl/tlb2w_chk.sv
module tlb2w_chk #(
  parameter int unsigned VA_W = 32,
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            res_valid,
  input logic            res_hit,
  input logic [PA_W-1:0] res_paddr,
  input logic [1:0]      lk_match,
  input logic [1:0]      lk_mru_vec,
  input logic            wr_clean_hit
);
  a_r2_res_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!res_hit || res_paddr[11:0] == $past(lk_vaddr[11:0])));

  a_r13_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_paddr == '0));

  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r5_single_mru: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_mru_vec));

  a_r9_clean_write_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && wr_clean_hit) |=> !res_hit);
endmodule

bind tlb2w_cache tlb2w_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_paddr    (res_paddr),
  .lk_match     (lk_match),
  .lk_mru_vec   (lk_mru_vec),
  .wr_clean_hit (wr_clean_hit)
);

// File: tb/sim_tlb2w_cache.sv
module sim_tlb2w_cache;
  localparam int PERIOD = 10;
  localparam logic [1:0] K_PRB = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_FT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, fill_valid = 1'b0;
  logic [31:0] lk_vaddr = '0, fill_vaddr = '0, fill_word = '0;
  logic [1:0]  lk_kind = '0, fill_kind = '0;
  logic        res_valid, res_hit;
  logic [31:0] res_paddr;

  int n_chk = 0, n_bad = 0;

  typedef struct { logic hit; logic [31:0] pa; string tg; } exp_t;
  exp_t q[$];

  tlb2w_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .fill_valid(fill_valid), .fill_vaddr(fill_vaddr),
    .fill_kind(fill_kind), .fill_word(fill_word), .res_valid(res_valid),
    .res_hit(res_hit), .res_paddr(res_paddr)
  );

  always #(PERIOD/2) clk = ~clk;

  // set 3 pages A,B,C; set 4 page D
  localparam logic [31:0] VA_A = 32'h1000_3abc, VA_B = 32'h2000_3123;
  localparam logic [31:0] VA_C = 32'h3000_3fff, VA_D = 32'h1000_4010;
  localparam logic [31:0] W_A  = 32'hAAAAA080, W_A2 = 32'hA1A1A080;
  localparam logic [31:0] W_AC = 32'hAAAAA000, W_B  = 32'hBBBBB080;
  localparam logic [31:0] W_C  = 32'hCCCCC080, W_D  = 32'hDDDDD080;

  function automatic logic [31:0] pa(input logic [31:0] w, input logic [31:0] va);
    return {w[31:12], va[11:0]};
  endfunction

  task automatic check(input logic ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic cyc(input logic lv, input logic [31:0] lva, input logic [1:0] lk,
                     input logic fv, input logic [31:0] fva, input logic [1:0] fk,
                     input logic [31:0] fw, input logic eh, input logic [31:0] epa,
                     input string tg);
    @(negedge clk);
    lk_valid = lv; lk_vaddr = lva; lk_kind = lk;
    fill_valid = fv; fill_vaddr = fva; fill_kind = fk; fill_word = fw;
    if (lv) q.push_back('{eh, epa, tg});
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k, input logic eh,
                      input logic [31:0] epa, input string tg);
    cyc(1'b1, va, k, 1'b0, '0, '0, '0, eh, epa, tg);
  endtask

  task automatic fill(input logic [31:0] va, input logic [1:0] k, input logic [31:0] w);
    cyc(1'b0, '0, '0, 1'b1, va, k, w, 1'b0, '0, "");
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops expectations as results appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && res_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected result", {31'd0, res_hit}, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(res_hit === e.hit, {e.tg, " hit"}, {31'd0, res_hit}, {31'd0, e.hit});
          check(res_paddr === e.pa, {e.tg, " paddr"}, res_paddr, e.pa);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(res_valid === 1'b0, "R1 reset res_valid", {31'd0, res_valid}, 32'd0);
    check(res_hit === 1'b0, "R1 reset res_hit", {31'd0, res_hit}, 32'd0);
    check(res_paddr === 32'd0, "R1 reset res_paddr", res_paddr, 32'd0);
    rst_n = 1'b1;
    look(VA_A, K_RD, 1'b0, 32'd0, "R1 R13 empty miss");

    // basic install and lookup
    fill(VA_A, K_RD, W_A);
    look(VA_A, K_RD, 1'b1, pa(W_A, VA_A), "R2 R5 hit");
    look(VA_A ^ 32'h0000_0555, K_FT, 1'b1, pa(W_A, VA_A ^ 32'h555), "R2 offset");
    look(32'h1100_3abc, K_RD, 1'b0, 32'd0, "R3 tag mismatch");
    fill(VA_D, K_WR, W_D);
    look(VA_D, K_RD, 1'b1, pa(W_D, VA_D), "R4 other set");
    look(VA_A, K_RD, 1'b1, pa(W_A, VA_A), "R4 set untouched");
    fill(32'h5000_7000, K_PRB, W_C);
    look(32'h5000_7000, K_RD, 1'b0, 32'd0, "R6 probe fill ignored");
    idle();

    // non-MRU eviction
    do_reset();
    fill(VA_A, K_RD, W_A);
    fill(VA_B, K_RD, W_B);
    look(VA_A, K_PRB, 1'b1, pa(W_A, VA_A), "R7 R11 two ways");
    look(VA_B, K_PRB, 1'b1, pa(W_B, VA_B), "R7 second way");
    fill(VA_C, K_RD, W_C);
    look(VA_A, K_RD, 1'b0, 32'd0, "R7 non-MRU evicted");
    look(VA_C, K_RD, 1'b1, pa(W_C, VA_C), "R7 new page");
    idle();

    // read hit refreshes MRU
    do_reset();
    fill(VA_A, K_RD, W_A);
    fill(VA_B, K_RD, W_B);
    look(VA_A, K_FT, 1'b1, pa(W_A, VA_A), "R8 fetch hit");
    fill(VA_C, K_RD, W_C);
    look(VA_B, K_RD, 1'b0, 32'd0, "R8 older evicted");
    look(VA_A, K_RD, 1'b1, pa(W_A, VA_A), "R8 recent kept");
    idle();

    // same-tag refill overwrites in place
    do_reset();
    fill(VA_A, K_RD, W_A);
    fill(VA_B, K_RD, W_B);
    fill(VA_A, K_RD, W_A2);
    look(VA_A, K_RD, 1'b1, pa(W_A2, VA_A), "R7 same tag replaced");
    look(VA_B, K_RD, 1'b1, pa(W_B, VA_B), "R7 other way kept");
    idle();

    // probe lookup leaves MRU alone
    do_reset();
    fill(VA_A, K_RD, W_A);
    fill(VA_B, K_RD, W_B);
    look(VA_A, K_PRB, 1'b1, pa(W_A, VA_A), "R11 probe hit");
    fill(VA_C, K_RD, W_C);
    look(VA_A, K_RD, 1'b0, 32'd0, "R11 probe left MRU");
    look(VA_B, K_RD, 1'b1, pa(W_B, VA_B), "R11 B kept");
    idle();

    // change bit handling
    do_reset();
    fill(VA_A, K_RD, W_AC);
    look(VA_A, K_RD, 1'b1, pa(W_AC, VA_A), "R9 clean read hits");
    look(VA_A, K_PRB, 1'b1, pa(W_AC, VA_A), "R11 probe hit clean");
    look(VA_A, K_WR, 1'b0, 32'd0, "R9 clean write miss");
    look(VA_A, K_WR, 1'b1, pa(W_AC, VA_A), "R9 second write hits");
    fill(VA_B, K_RD, W_B);
    look(VA_B, K_WR, 1'b1, pa(W_B, VA_B), "R10 dirty write hit");
    idle();

    // clean write miss does not refresh MRU
    do_reset();
    fill(VA_A, K_RD, W_AC);
    fill(VA_B, K_RD, W_B);
    look(VA_A, K_WR, 1'b0, 32'd0, "R9 clean write miss 2");
    fill(VA_C, K_RD, W_C);
    look(VA_A, K_RD, 1'b0, 32'd0, "R9 MRU unchanged");
    look(VA_B, K_RD, 1'b1, pa(W_B, VA_B), "R9 B kept");
    idle();

    // lookup and refill to the same set in one cycle
    do_reset();
    fill(VA_A, K_RD, W_A);
    fill(VA_B, K_RD, W_B);
    cyc(1'b1, VA_A, K_RD, 1'b1, VA_C, K_RD, W_C, 1'b1, pa(W_A, VA_A), "R12 pre-fill view");
    look(VA_A, K_RD, 1'b0, 32'd0, "R12 lookup update dropped");
    look(VA_B, K_RD, 1'b1, pa(W_B, VA_B), "R12 B kept");
    look(VA_C, K_RD, 1'b1, pa(W_C, VA_C), "R12 C installed");
    idle();

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 results outstanding", q.size(), 32'd0);
    summary();
  end
endmodule